// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner and Lock Detector

This block sits behind a clock-and-data recovery stage that delivers one sample per bit on every clock. The serial stream is cut into 12-bit frames. Each frame is a start bit (1), then ten payload bits least significant first, then a stop bit (0). The start and stop bits together form the clock edge carried inside the stream. The aligner looks for the synchronisation word: six ones followed by six zeros, entered on a 0-to-1 transition. It confirms the frame position, then unpacks every later frame into a 10-bit word with a one-cycle strobe, and reports link status on an active-low lock flag.

The controller has three named states. SEARCH examines every bit position for a sync word. VERIFY counts consecutive sync words at the same frame phase. LOCKED checks the clock bits of each frame and delivers payload. The transitions are:
- SEARCH→VERIFY (sync found): a sync word preceded by a 0 restarts the frame phase.
- VERIFY→VERIFY (sync repeat): another sync word at the frame boundary raises the count.
- VERIFY→LOCKED (sync confirmed): the fourth consecutive sync word declares lock.
- VERIFY→SEARCH (sync broken): any other frame at the boundary abandons the attempt.
- LOCKED→LOCKED (good frame or tolerated miss): the link stays up.
- LOCKED→SEARCH (clock lost): the fourth consecutive frame with bad clock bits drops lock.
- any→SEARCH (powerdown): powerdown forces this transition in every state.

An output enable masks the word and strobe without touching the state.

Top module: `frame_lock_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lock_n` is 1, `word_stb` is 0 and `word_q` is 0.
- R2: Lock is declared after four consecutive sync words at one frame phase. A sync word, in time order, is 1,1,1,1,1,1,0,0,0,0,0,0, and the first one must be preceded by a 0. `lock_n` falls in the cycle after the last bit of the fourth sync word is sampled.
- R3: A locked frame is sent in time order as start 1, payload bits 0 to 9, stop 0. `word_q` presents the payload with the first payload bit as bit 0.
- R4: `word_stb` is high for exactly one cycle, the cycle after the stop bit of a good payload frame is sampled. `word_q` is valid in that cycle.
- R5: A sync word received while locked produces no strobe.
- R6: While locked, up to three consecutive frames whose start bit is not 1 or whose stop bit is not 0 keep the lock. A single good frame resets the miss count.
- R7: A frame with bad clock bits produces no strobe.
- R8: The fourth consecutive bad frame raises `lock_n` in the cycle after its stop position is sampled, and `word_q` returns to 0.
- R9: While `lock_n` is 1, `word_stb` stays 0 and `word_q` is 0.
- R10: A frame other than the sync word arriving during VERIFY returns to SEARCH, and the count of four starts again.
- R11: With `out_en` low, `word_q` and `word_stb` are 0 while `lock_n` keeps tracking the link.
- R12: With `pwr_n` low, the block returns to SEARCH and `lock_n` is 1 from the next cycle. A full four-word resynchronisation is needed afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit | input | 1 | Recovered serial data bit |
| pwr_n | input | 1 | Active-low powerdown; low forces search |
| out_en | input | 1 | Enables the word and strobe outputs |
| word_q | output | 10 | Unpacked payload word |
| word_stb | output | 1 | One-cycle strobe per delivered word |
| lock_n | output | 1 | Active-low lock indicator |

## Verification
A frame-phase error shows up one frame after lock: the unpacked words come out rotated, and the scoreboard reports them within 12 bit times. A wrong sync or miss counter moves the edge of `lock_n` by whole frames, so the bench samples `lock_n` in the exact cycle after each frame boundary. A strobe leaking from sync words, bad frames or the unlocked state appears as a word the scoreboard does not expect. That strobe is seen at the next falling clock edge.

// File: rtl/efa_pkg.sv
package efa_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } align_st_e;
endpackage

// File: rtl/efa_window.sv
module efa_window #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               bit_i,
    input  logic               restart,
    output logic [FRAME_W-1:0] win,
    output logic               prev_bit,
    output logic               frame_end
);
    localparam int PH_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sr_q;
    logic [PH_W-1:0]    ph_q;

    // newest bit enters at the top; oldest (start) lands in bit 0
    assign win       = {bit_i, sr_q[FRAME_W-1:1]};
    assign prev_bit  = sr_q[0];
    assign frame_end = (ph_q == PH_W'(FRAME_W-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
            ph_q <= '0;
        end else if (clr) begin
            sr_q <= '0;
            ph_q <= '0;
        end else begin
            sr_q <= win;
            if (restart || frame_end) ph_q <= '0;
            else                      ph_q <= ph_q + 1'b1;
        end
    end

    // frame position never leaves the 12-bit frame (R3)
    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q < PH_W'(FRAME_W));
endmodule

// File: rtl/efa_fsm.sv
module efa_fsm
    import efa_pkg::*;
#(
    parameter int FRAME_W     = 12,
    parameter int LOCK_SYNCS  = 4,
    parameter int LOSS_FRAMES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_n,
    input  logic [FRAME_W-1:0] win,
    input  logic               prev_bit,
    input  logic               frame_end,
    output logic               restart,
    output logic               load,
    output logic               drop,
    output logic               lock_n
);
    localparam int HALF  = FRAME_W / 2;
    localparam int CMAX  = (LOCK_SYNCS > LOSS_FRAMES) ? LOCK_SYNCS : LOSS_FRAMES;
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam logic [FRAME_W-1:0] SYNC_WORD = (FRAME_W'(1) << HALF) - FRAME_W'(1);

    align_st_e        st_q, st_d;
    logic [CNT_W-1:0] sync_q, sync_d;
    logic [CNT_W-1:0] miss_q, miss_d;
    logic             is_sync, clk_ok;

    assign is_sync = (win == SYNC_WORD);
    assign clk_ok  = win[0] && !win[FRAME_W-1];

    always_comb begin
        st_d    = st_q;
        sync_d  = sync_q;
        miss_d  = miss_q;
        restart = 1'b0;
        load    = 1'b0;
        drop    = 1'b0;
        if (!pwr_n) begin
            st_d   = ST_SEARCH;
            sync_d = '0;
            miss_d = '0;
            drop   = (st_q == ST_LOCKED);
        end else begin
            unique case (st_q)
                ST_SEARCH: begin
                    if (is_sync && !prev_bit) begin
                        restart = 1'b1;
                        st_d    = ST_VERIFY;
                        sync_d  = CNT_W'(1);
                    end
                end
                ST_VERIFY: begin
                    if (frame_end) begin
                        if (is_sync) begin
                            if (sync_q == CNT_W'(LOCK_SYNCS-1)) begin
                                st_d   = ST_LOCKED;
                                sync_d = '0;
                                miss_d = '0;
                            end else begin
                                sync_d = sync_q + 1'b1;
                            end
                        end else begin
                            st_d   = ST_SEARCH;
                            sync_d = '0;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (frame_end) begin
                        if (clk_ok) begin
                            miss_d = '0;
                            load   = !is_sync;
                        end else if (miss_q == CNT_W'(LOSS_FRAMES-1)) begin
                            st_d   = ST_SEARCH;
                            miss_d = '0;
                            drop   = 1'b1;
                        end else begin
                            miss_d = miss_q + 1'b1;
                        end
                    end
                end
                default: st_d = ST_SEARCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_SEARCH;
            sync_q <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_d;
            sync_q <= sync_d;
            miss_q <= miss_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_n <= 1'b1;
        else        lock_n <= (st_d != ST_LOCKED);
    end

    assert_lock_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> ($past(st_q) == ST_VERIFY && $past(sync_q) == CNT_W'(LOCK_SYNCS-1)));

    assert_miss_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q < CNT_W'(LOSS_FRAMES));

    assert_loss_hyst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_n) && $past(pwr_n)) |-> ($past(miss_q) == CNT_W'(LOSS_FRAMES-1)));

    assert_load_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (st_q == ST_LOCKED && !lock_n));

    assert_powerdown_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> lock_n);
endmodule

// File: rtl/efa_out.sv
module efa_out #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_n,
    input  logic              out_en,
    input  logic              lock_n,
    input  logic              load,
    input  logic              drop,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] word_q,
    output logic              word_stb
);
    logic [DATA_W-1:0] word_r;
    logic              stb_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_r <= '0;
            stb_r  <= 1'b0;
        end else if (!pwr_n || drop) begin
            word_r <= '0;
            stb_r  <= 1'b0;
        end else begin
            stb_r <= load;
            if (load) word_r <= data_i;
        end
    end

    assign word_q   = (out_en && !lock_n) ? word_r : '0;
    assign word_stb = out_en && stb_r && !lock_n;

    assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_r |=> !stb_r);

    assert_stb_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stb_r |-> !lock_n);
endmodule

// File: rtl/frame_lock_rx.sv
module frame_lock_rx #(
    parameter int DATA_W      = 10,
    parameter int LOCK_SYNCS  = 4,
    parameter int LOSS_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              pwr_n,
    input  logic              out_en,
    output logic [DATA_W-1:0] word_q,
    output logic              word_stb,
    output logic              lock_n
);
    localparam int FRAME_W = DATA_W + 2;

    logic [FRAME_W-1:0] win;
    logic prev_bit, frame_end, restart, load, drop;

    efa_window #(.FRAME_W(FRAME_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(!pwr_n), .bit_i(ser_bit),
        .restart(restart), .win(win), .prev_bit(prev_bit), .frame_end(frame_end)
    );

    efa_fsm #(.FRAME_W(FRAME_W), .LOCK_SYNCS(LOCK_SYNCS), .LOSS_FRAMES(LOSS_FRAMES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .win(win), .prev_bit(prev_bit),
        .frame_end(frame_end), .restart(restart), .load(load), .drop(drop), .lock_n(lock_n)
    );

    efa_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .out_en(out_en), .lock_n(lock_n),
        .load(load), .drop(drop), .data_i(win[FRAME_W-2:1]),
        .word_q(word_q), .word_stb(word_stb)
    );
endmodule

// File: tb/frame_lock_rx_tb_top.sv
module frame_lock_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_bit = 1'b0;
    logic          pwr_n = 1'b1;
    logic          out_en = 1'b1;
    logic [DW-1:0] word_q;
    logic          word_stb;
    logic          lock_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DW-1:0] exp_q[$];
    bit prev_stb = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_lock_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .pwr_n(pwr_n), .out_en(out_en),
        .word_q(word_q), .word_stb(word_stb), .lock_n(lock_n)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        ser_bit = b;
    endtask

    // driver: pushes the expected word before the frame goes out
    task automatic send_frame(logic st, logic [DW-1:0] d, logic sp, bit expect_out);
        if (expect_out) exp_q.push_back(d);
        send_bit(st);
        for (int i = 0; i < DW; i++) send_bit(d[i]);
        send_bit(sp);
    endtask

    task automatic send_sync();
        send_frame(1'b1, 10'h01F, 1'b0, 1'b0);
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    // monitor: pops and compares on every strobe
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (word_stb) begin
                check(!prev_stb, "R4 strobe wider than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected strobe", int'(word_q), 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(word_q == e, "R3 word value", int'(word_q), int'(e));
                end
            end
            prev_stb = word_stb;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(lock_n == 1'b1, "R1 lock_n in reset", int'(lock_n), 1);
        check(word_stb == 1'b0 && word_q == '0, "R1 outputs in reset", int'(word_q), 0);
        rst_n = 1'b1;
        settle();
        check(lock_n == 1'b1, "R1 lock_n after reset", int'(lock_n), 1);

        repeat (5) send_bit(1'b0);
        repeat (3) send_sync();
        settle();
        check(lock_n == 1'b1, "R2 not locked after three syncs", int'(lock_n), 1);
        send_sync();
        settle();
        check(lock_n == 1'b0, "R2 locked after fourth sync", int'(lock_n), 0);

        send_frame(1'b1, 10'h2A5, 1'b0, 1'b1);
        send_frame(1'b1, 10'h001, 1'b0, 1'b1);
        send_frame(1'b1, 10'h3FF, 1'b0, 1'b1);
        send_frame(1'b1, 10'h200, 1'b0, 1'b1);
        settle();
        check(word_stb == 1'b1 && word_q == 10'h200, "R4 strobe after last stop bit", int'(word_q), 'h200);

        send_sync();
        settle();
        check(word_stb == 1'b0, "R5 no strobe for sync while locked", int'(word_stb), 0);

        // R6/R7: three bad frames tolerated, then a good one clears the count
        repeat (3) send_frame(1'b0, 10'h155, 1'b0, 1'b0);
        settle();
        check(lock_n == 1'b0, "R6 lock kept after three bad frames", int'(lock_n), 0);
        check(word_stb == 1'b0, "R7 no strobe for bad frame", int'(word_stb), 0);
        send_frame(1'b1, 10'h0C3, 1'b0, 1'b1);
        repeat (3) send_frame(1'b1, 10'h0F0, 1'b1, 1'b0);
        settle();
        check(lock_n == 1'b0, "R6 miss count cleared by good frame", int'(lock_n), 0);
        send_frame(1'b1, 10'h0F0, 1'b1, 1'b0);
        settle();
        check(lock_n == 1'b1, "R8 lock lost on fourth bad frame", int'(lock_n), 1);
        check(word_q == '0, "R8 word cleared on loss", int'(word_q), 0);

        send_frame(1'b1, 10'h0AA, 1'b0, 1'b0);
        send_frame(1'b1, 10'h133, 1'b0, 1'b0);
        settle();
        check(word_stb == 1'b0 && word_q == '0, "R9 silent while unlocked", int'(word_q), 0);

        // R10: interrupted verification restarts the count
        repeat (2) send_sync();
        send_frame(1'b1, 10'h155, 1'b0, 1'b0);
        repeat (3) send_sync();
        settle();
        check(lock_n == 1'b1, "R10 count restarted after non-sync frame", int'(lock_n), 1);
        send_sync();
        settle();
        check(lock_n == 1'b0, "R2 relock after four syncs", int'(lock_n), 0);

        // R11: output enable masks the word and strobe only
        out_en = 1'b0;
        send_frame(1'b1, 10'h3C1, 1'b0, 1'b0);
        settle();
        check(word_stb == 1'b0 && word_q == '0, "R11 masked outputs", int'(word_q), 0);
        check(lock_n == 1'b0, "R11 lock unaffected", int'(lock_n), 0);
        send_sync();
        out_en = 1'b1;
        send_frame(1'b1, 10'h0E7, 1'b0, 1'b1);

        // R12: powerdown
        @(negedge clk);
        pwr_n = 1'b0;
        ser_bit = 1'b0;
        settle();
        check(lock_n == 1'b1, "R12 lock_n high in powerdown", int'(lock_n), 1);
        repeat (3) @(negedge clk);
        pwr_n = 1'b1;
        repeat (4) send_bit(1'b0);
        send_frame(1'b1, 10'h2D2, 1'b0, 1'b0);
        settle();
        check(lock_n == 1'b1, "R12 no lock without resync", int'(lock_n), 1);
        repeat (4) send_sync();
        settle();
        check(lock_n == 1'b0, "R12 relock after powerdown", int'(lock_n), 0);
        send_frame(1'b1, 10'h1B4, 1'b0, 1'b1);
        repeat (6) send_bit(1'b0);

        check(exp_q.size() == 0, "R3 all expected words delivered", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule